// File: doc/BRIEF.md
# Event Precedence Watchdog

This block watches two event strobes, each a single-cycle tick sampled on a common clock. It enforces one ordering rule: the k-th tick of the leading event `tick_a` must come in an earlier cycle than the k-th tick of the trailing event `tick_b`. It is passive. It never stalls either source; it only reports when the rule is broken.

A saturating lead counter records how many leading ticks are still unmatched. A trailing tick that arrives while the lead is zero is a violation. This holds even when a leading tick arrives in the same cycle, because same-cycle arrival does not count as strictly earlier.

Each violation gives a one-cycle `viol` pulse and sets the sticky `err` flag. Saturation of the counter can optionally be reported on `ovf`. All outputs are registered, so they reflect the inputs sampled at the previous rising edge.

Top module: `prec_watch`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `lead_cnt`, `viol`, `err` and `ovf` to zero.
- R2: A clock edge where only `tick_a` is high raises `lead_cnt` by one, unless it is already at its all-ones maximum.
- R3: A clock edge where only `tick_b` is high and `lead_cnt` is nonzero lowers `lead_cnt` by one, and gives no violation.
- R4: An edge with neither tick high leaves `lead_cnt` unchanged. So does an edge with both ticks high while `lead_cnt` is nonzero.
- R5: An edge where `tick_b` is high and `lead_cnt` is zero makes `viol` high for the following cycle, and `lead_cnt` stays at zero.
- R6: A same-cycle tick of `tick_a` and `tick_b` while `lead_cnt` is zero is a violation as in R5, and the lead is not raised.
- R7: `err` goes high together with the first `viol` pulse and stays high until reset.
- R8: At its maximum, `lead_cnt` saturates rather than wrapping to zero.
- R9: With `OVF_EN`=1, `ovf` is high for one cycle after each edge where only `tick_a` is high and `lead_cnt` is at maximum. With `OVF_EN`=0, `ovf` stays low.
- R10: `tick_a` alone never causes `viol`, in any pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Leading event strobe |
| tick_b | input | 1 | Trailing event strobe |
| lead_cnt | output | CNT_W | Unmatched leading ticks |
| viol | output | 1 | One-cycle violation pulse |
| err | output | 1 | Sticky violation flag |
| ovf | output | 1 | Saturation pulse |

## Verification
The bench builds the block with `CNT_W`=3 and `OVF_EN`=1. The narrow counter brings saturation and the overflow pulse within reach after only seven leading ticks, and the walk back down to zero lead takes only a few more cycles. A behavioural model using integer arithmetic is compared against all four outputs on every cycle. That comparison covers same-cycle ticks at zero and nonzero lead, as well as a reset that clears the sticky flag.

// File: rtl/prec_watch.sv
module prec_watch #(
  parameter int CNT_W  = 4,
  parameter bit OVF_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a,
  input  logic             tick_b,
  output logic [CNT_W-1:0] lead_cnt,
  output logic             viol,
  output logic             err,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic at_zero, at_max, bad, up, down;

  assign at_zero = (lead_cnt == '0);
  assign at_max  = (lead_cnt == CNT_MAX);
  assign bad     = tick_b && at_zero;
  assign up      = tick_a && !tick_b && !at_max;
  assign down    = tick_b && !tick_a && !bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_cnt <= '0;
      viol     <= 1'b0;
      err      <= 1'b0;
    end else begin
      viol <= bad;
      err  <= err | bad;
      if (up)
        lead_cnt <= lead_cnt + CNT_ONE;
      else if (down)
        lead_cnt <= lead_cnt - CNT_ONE;
    end
  end

  generate
    if (OVF_EN) begin : g_ovf
      always_ff @(posedge clk) begin
        if (rst) ovf <= 1'b0;
        else     ovf <= tick_a && !tick_b && at_max;
      end
    end else begin : g_no_ovf
      assign ovf = 1'b0;
    end
  endgenerate
endmodule

module prec_watch_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_a,
  input logic             tick_b,
  input logic [CNT_W-1:0] lead_cnt,
  input logic             viol,
  input logic             err,
  input logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  a_r5_zero_b_flags: assert property (@(posedge clk) disable iff (rst)
    (tick_b && lead_cnt == '0) |=> (viol && lead_cnt == '0));
  a_r2_inc: assert property (@(posedge clk) disable iff (rst)
    (tick_a && !tick_b && lead_cnt != CNT_MAX) |=> lead_cnt == $past(lead_cnt) + CNT_ONE);
  a_r3_dec: assert property (@(posedge clk) disable iff (rst)
    (tick_b && !tick_a && lead_cnt != '0) |=> (lead_cnt == $past(lead_cnt) - CNT_ONE && !viol));
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_a && lead_cnt == CNT_MAX) |=> lead_cnt == CNT_MAX);
  a_r9_ovf_at_max: assert property (@(posedge clk) disable iff (rst)
    ovf |-> lead_cnt == CNT_MAX);
  a_r10_a_harmless: assert property (@(posedge clk) disable iff (rst)
    !tick_b |=> !viol);
endmodule

bind prec_watch prec_watch_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_prec_watch.sv
module test_prec_watch;
  localparam int CNT_W = 3;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_a = 1'b0, tick_b = 1'b0;
  logic [CNT_W-1:0] lead_cnt;
  logic viol, err, ovf;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_cnt = 0, m_viol = 0, m_err = 0, m_ovf = 0;

  always #4 clk = ~clk;

  prec_watch #(.CNT_W(CNT_W), .OVF_EN(1'b1)) i_prec_watch (
    .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b),
    .lead_cnt(lead_cnt), .viol(viol), .err(err), .ovf(ovf));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " lead_cnt"}, int'(lead_cnt), m_cnt);
    chk({tag, " viol"}, int'(viol), m_viol);
    chk({tag, " err"}, int'(err), m_err);
    chk({tag, " ovf"}, int'(ovf), m_ovf);
  endtask

  task automatic step(input logic a, input logic b, input string tag);
    int v, o;
    tick_a = a; tick_b = b;
    @(posedge clk);
    v = (b && m_cnt == 0) ? 1 : 0;
    o = 0;
    if (v == 0) begin
      if (a && !b) begin
        if (m_cnt == MAXV) o = 1; else m_cnt++;
      end else if (b && !a) m_cnt--;
    end
    m_viol = v; m_err = m_err | v; m_ovf = o;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick_a = 1'b0; tick_b = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_viol = 0; m_err = 0; m_ovf = 0;
    compare("R1 reset");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 3; i++) step(1, 0, "R2 lead up");
    for (int i = 0; i < 2; i++) step(0, 1, "R3 lead down");
    step(1, 1, "R4 both nonzero");
    step(0, 0, "R4 idle");
    step(1, 1, "R4 both nonzero");
    step(0, 1, "R3 to zero");
    step(0, 1, "R5 b at zero");
    step(0, 1, "R5 b at zero again");
    for (int i = 0; i < 3; i++) step(0, 0, "R7 sticky hold");
    step(1, 1, "R6 both at zero");
    step(0, 0, "R6 after");
    for (int i = 0; i < MAXV + 3; i++) step(1, 0, "R8 R9 saturate");
    step(1, 1, "R4 both at max");
    for (int i = 0; i < MAXV; i++) step(0, 1, "R3 drain");
    step(0, 1, "R5 drained");
    do_reset();
    for (int i = 0; i < 12; i++) step(i % 3 != 1, 0, "R10 a pattern");
    for (int i = 0; i < 6; i++) step(i % 2 == 0, 1, "R4 R3 mixed");
    chk("R10 no err", int'(err), 0);
    step(1, 0, "R2 final");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule